// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the controller side of the two-wire Ethernet PHY management bus. A host inside the chip hands it one request at a time: a read or write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block divides the system clock to make the management clock. It serialises the whole frame: a run of ones, a start pattern, an opcode, both addresses, a turnaround field and the data. For reads it captures the 16 data bits that the PHY drives back.

The data line is bidirectional, so the block drives it through a separate output value and output enable, and observes it through an input. Board pull-up logic is assumed. On a read the block checks that the PHY pulls the second turnaround bit low. If that bit stays high, no PHY is answering. The block then clocks a further run of idle cycles so that any confused PHY can resynchronise. It returns all-ones data and raises a no-response flag. Each finished request ends with a one-cycle done pulse.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever idle, `mdc` is low, `mdio_oe` is low (line released), and `busy` and `done` are low.
- R2: Every frame begins with 33 consecutive 1 bits, driven, followed by the start pattern 0 then 1.
- R3: The two opcode bits follow the start pattern: 1,0 for a read and 0,1 for a write.
- R4: The 5-bit PHY address and then the 5-bit register address follow the opcode, each sent most significant bit first.
- R5: On a write the master drives the turnaround bits 1 then 0, then the 16 data bits most significant bit first, for a 65-bit frame.
- R6: On a read, `mdio_oe` is low from bit 47 (the first turnaround bit) to the end. Bits 49 to 64 are sampled on rising `mdc` edges and assembled most significant bit first into `rdata`.
- R7: On a read, if the second turnaround bit (bit 48) is sampled as 1, the master clocks 32 further `mdc` cycles with the line released, for 81 bit periods in total. It then sets `rdata` to 16'hFFFF and `no_resp` to 1.
- R8: Each `mdc` half period lasts `half_div`+1 system clocks, using the value captured when the request is accepted. A bit period is a low half followed by a high half. `mdio_o` and `mdio_oe` change only at the start of a low half and stay constant while `mdc` is high.
- R9: `busy` rises in the cycle after a request is accepted and stays high until the last bit period ends. `done` is then a single-cycle pulse, with `busy` low and the line released.
- R10: `req` is ignored while `busy` is high: the frame in progress is unchanged and no new frame follows it.
- R11: `rdata` and `no_resp` hold their values from the end of a transaction until the next request is accepted. Acceptance clears `no_resp` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | DIV_W | MDC half period minus one, in system clocks |
| req | input | 1 | Request strobe, taken only while idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data (all ones when no PHY answered) |
| no_resp | output | 1 | Read saw no turnaround response |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line observed value |

## Verification
On every cycle the assertions check four things: the line and clock stay quiet when idle, the data line is frozen while the clock is high, `done` is a lone pulse at which everything is released, and a no-response flag always comes with all-ones data. They also check that the read results hold between transactions. The bit content of each frame cannot be shown by a property: the field order, address and data ordering, turnaround drive on writes, data capture on reads, the length of the recovery run and the ignoring of requests mid-frame. The bench shows these by comparing the pins against its bit-level model on every clock, at several divider settings and with a responding and an absent PHY.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_LEN       = 33;
    localparam int ADDR_W        = 5;
    localparam int DATA_W        = 16;
    localparam int RECOVER_LEN   = 32;
    localparam int HDR_LEN       = PRE_LEN + 2 + 2 + 2 * ADDR_W;
    localparam int FRAME_LEN     = HDR_LEN + 2 + DATA_W;
    localparam int READ_FAIL_LEN = HDR_LEN + 2 + RECOVER_LEN;
    localparam int IDX_W         = $clog2(READ_FAIL_LEN + 1);

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    function automatic logic [FRAME_LEN-1:0] build_frame(mdio_req_t r);
        logic [1:0] opb;
        opb = r.rd ? OP_READ : OP_WRITE;
        return {{PRE_LEN{1'b1}}, 2'b01, opb, r.phy, r.regad, 2'b10, r.wdata};
    endfunction
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lim <= '0;
        end else if (start) begin
            cnt <= '0;
            lim <= half_div;
        end else if (run) begin
            if (cnt == lim) cnt <= '0;
            else            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && !start && (cnt == lim);
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_req_t         req_in,
    input  logic              tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              no_resp,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam logic [IDX_W-1:0] HDR_I  = IDX_W'(HDR_LEN);
    localparam logic [IDX_W-1:0] TA2_I  = IDX_W'(HDR_LEN + 1);
    localparam logic [IDX_W-1:0] LEN_I  = IDX_W'(FRAME_LEN);
    localparam logic [IDX_W-1:0] END_OK = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] END_NR = IDX_W'(READ_FAIL_LEN - 1);

    logic [FRAME_LEN-1:0] frame;
    logic                 rd;
    logic                 recover;
    logic [IDX_W-1:0]     idx;
    logic [IDX_W-1:0]     pos;
    logic [IDX_W-1:0]     last_idx;
    logic                 frame_bit;

    always_comb begin
        pos       = END_OK - idx;
        frame_bit = (idx < LEN_I) ? frame[pos] : 1'b0;
        last_idx  = recover ? END_NR : END_OK;
        mdio_oe   = busy && (rd ? (idx < HDR_I) : 1'b1);
        mdio_o    = mdio_oe && frame_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame   <= '0;
            rd      <= 1'b0;
            recover <= 1'b0;
            idx     <= '0;
            mdc     <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
            no_resp <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                frame   <= build_frame(req_in);
                rd      <= req_in.rd;
                recover <= 1'b0;
                idx     <= '0;
                mdc     <= 1'b0;
                busy    <= 1'b1;
                rdata   <= '0;
                no_resp <= 1'b0;
            end else if (busy && tick) begin
                if (!mdc) begin
                    mdc <= 1'b1;
                    if (rd) begin
                        if (idx == TA2_I && mdio_i) begin
                            recover <= 1'b1;
                            no_resp <= 1'b1;
                            rdata   <= '1;
                        end else if (idx > TA2_I && idx < LEN_I && !recover) begin
                            rdata <= {rdata[DATA_W-2:0], mdio_i};
                        end
                    end
                end else begin
                    mdc <= 1'b0;
                    if (idx == last_idx) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));
    // R8
    high_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mdc && !mdio_oe));
    // R7
    nores_ones_chk: assert property (@(posedge clk) disable iff (rst)
        no_resp |-> (rdata == '1));
    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(rdata) && $stable(no_resp)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_div,
    input  logic             req,
    input  logic             req_read,
    input  logic [4:0]       req_phy,
    input  logic [4:0]       req_reg,
    input  logic [15:0]      req_wdata,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rdata,
    output logic             no_resp,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic      start;
    logic      tick;
    mdio_req_t req_pk;

    assign start  = req && !busy;
    assign req_pk = '{rd: req_read, phy: req_phy, regad: req_reg, wdata: req_wdata};

    mdio_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .run      (busy),
        .half_div (half_div),
        .tick     (tick)
    );

    mdio_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .req_in  (req_pk),
        .tick    (tick),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .done    (done),
        .rdata   (rdata),
        .no_resp (no_resp),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );
endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  half_div = '0;
    logic        req = 1'b0;
    logic        req_read = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, no_resp, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mdio_master #(.DIV_W(8)) u0 (
        .clk(clk), .rst(rst), .half_div(half_div), .req(req), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .no_resp(no_resp),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string bit_tag(int b, bit rd, bit present);
        if (b < 35) return "R2";
        if (b < 37) return "R3";
        if (b < 47) return "R4";
        if (!rd) return "R5";
        if (!present) return "R7";
        return "R6";
    endfunction

    task automatic run_txn(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd,
                           int hdiv, bit present, logic [15:0] pdata, bit spam);
        logic exp_o[$];
        logic exp_oe[$];
        logic resp[$];
        int   h, nbits, lim;
        logic [15:0] exp_rd;
        exp_o.delete(); exp_oe.delete(); resp.delete();
        h = hdiv + 1;
        for (int i = 0; i < 33; i++) begin exp_o.push_back(1'b1); exp_oe.push_back(1'b1); end
        exp_o.push_back(1'b0); exp_o.push_back(1'b1);
        exp_o.push_back(rd ? 1'b1 : 1'b0); exp_o.push_back(rd ? 1'b0 : 1'b1);
        repeat (4) exp_oe.push_back(1'b1);
        for (int i = 4; i >= 0; i--) begin exp_o.push_back(phy[i]); exp_oe.push_back(1'b1); end
        for (int i = 4; i >= 0; i--) begin exp_o.push_back(rg[i]); exp_oe.push_back(1'b1); end
        for (int i = 0; i < 47; i++) resp.push_back(1'b1);
        if (!rd) begin
            exp_o.push_back(1'b1); exp_o.push_back(1'b0);
            for (int i = 15; i >= 0; i--) exp_o.push_back(wd[i]);
            repeat (18) exp_oe.push_back(1'b1);
            nbits = 65;
            exp_rd = 16'h0000;
        end else begin
            nbits = present ? 65 : 81;
            for (int i = 47; i < nbits; i++) begin exp_o.push_back(1'b0); exp_oe.push_back(1'b0); end
            resp.push_back(1'b1);
            resp.push_back(present ? 1'b0 : 1'b1);
            for (int i = 15; i >= 0; i--) resp.push_back(present ? pdata[i] : 1'b1);
            for (int i = 0; i < 16; i++) resp.push_back(1'b1);
            exp_rd = present ? pdata : 16'hFFFF;
        end
        @(negedge clk);
        half_div = 8'(hdiv); req_read = rd; req_phy = phy; req_reg = rg; req_wdata = wd; req = 1'b1;
        lim = nbits * 2 * h;
        for (int k = 0; k <= lim + 1; k++) begin
            int b;
            @(negedge clk);
            if (k == 0) begin
                req = 1'b0;
                chk("R11", "no_resp cleared on accept", no_resp, 0);
            end
            if (spam && k == 40) begin
                req = 1'b1; req_read = ~rd; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
            end
            if (spam && k == 41) req = 1'b0;
            b = k / (2 * h);
            if (k < lim) begin
                mdio_i = exp_oe[b] ? exp_o[b] : resp[b];
                chk("R9", "busy in frame", busy, 1);
                chk("R9", "done in frame", done, 0);
                chk("R8", "mdc phase", mdc, ((k % (2 * h)) >= h) ? 1 : 0);
                chk(bit_tag(b, rd, present), "mdio_oe", mdio_oe, exp_oe[b]);
                if (exp_oe[b]) chk(bit_tag(b, rd, present), "mdio_o", mdio_o, exp_o[b]);
            end else if (k == lim) begin
                mdio_i = 1'b1;
                chk("R9", "done pulse", done, 1);
                chk("R9", "busy at end", busy, 0);
                chk("R9", "released at end", mdio_oe, 0);
                chk("R9", "mdc low at end", mdc, 0);
            end else begin
                chk("R9", "done single cycle", done, 0);
            end
        end
        if (rd) begin
            chk(present ? "R6" : "R7", "rdata", rdata, exp_rd);
            chk("R7", "no_resp", no_resp, present ? 0 : 1);
        end
        repeat (6) @(negedge clk);
        chk(spam ? "R10" : "R1", "idle busy", busy, 0);
        chk("R1", "idle oe", mdio_oe, 0);
        chk("R1", "idle mdc", mdc, 0);
        if (rd) begin
            chk("R11", "rdata held", rdata, exp_rd);
            chk("R11", "no_resp held", no_resp, present ? 0 : 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog run incomplete actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset mdc", mdc, 0);
        chk("R1", "reset oe", mdio_oe, 0);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset done", done, 0);
        run_txn(1'b0, 5'h11, 5'h0A, 16'hA5C3, 0, 1'b1, 16'h0000, 1'b0);
        run_txn(1'b1, 5'h03, 5'h15, 16'h0000, 1, 1'b1, 16'h1234, 1'b0);
        run_txn(1'b1, 5'h1F, 5'h02, 16'h0000, 0, 1'b0, 16'h0000, 1'b0);
        run_txn(1'b0, 5'h1F, 5'h00, 16'h8001, 3, 1'b1, 16'h0000, 1'b1);
        run_txn(1'b1, 5'h00, 5'h1F, 16'h0000, 2, 1'b1, 16'h8001, 1'b1);
        run_txn(1'b1, 5'h0C, 5'h07, 16'h0000, 1, 1'b0, 16'h0000, 1'b0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule